// File: doc/BRIEF.md
# Fixed-Point Arithmetic Unit with Mode Select

This block is a 32-bit fixed-point arithmetic unit. Each operand is presented as a 24-bit integer field and an 8-bit fraction field. The two fields are concatenated into a single two's-complement word, so the binary point sits between bit 8 and bit 7. A 2-bit mode input picks the operation: add or subtract, a full-width signed multiply, or a signed divide that returns both quotient and remainder.

The front end uses a valid/ready handshake with a registered input stage, and results come out of a registered output stage together with a one-cycle valid pulse.

- Add, subtract, multiply and the reserved code each finish in a fixed two-cycle latency. These operations can be issued back to back, one per clock.
- Divide is iterative and produces one quotient bit per clock. While a divide is in flight, the unit lowers its ready output and accepts no new operation until the divide result has been delivered.

Top module: `fx_arith_unit`

## Requirements
- R1: Operand A is formed as {a_int_i, a_frac_i}, with the integer field in bits 31:8 and the fraction field in bits 7:0. Operand B is formed the same way from b_int_i and b_frac_i. Both are treated as signed two's-complement words.
- R2: With mode 2'b00 and sub_i=0, res_lo_o is A+B modulo 2^32 and res_hi_o is zero. For example, 0x00000F30 + 0x00000F30 = 0x00001E60.
- R3: With mode 2'b00 and sub_i=1, res_lo_o is A-B modulo 2^32 and res_hi_o is zero.
- R4: With mode 2'b01, {res_hi_o, res_lo_o} is the 64-bit signed product A*B. For example, 0x00001F03 * 0x0000070F = 0x0000000000DAE62D.
- R5: With mode 2'b10 and B nonzero, res_lo_o is the signed quotient truncated toward zero and res_hi_o is the remainder, which takes the sign of A. For example, 13/3 gives quotient 4 and remainder 1.
- R6: With mode 2'b10 and B equal to zero, res_lo_o is all ones, res_hi_o equals A, and div_zero_o is 1.
- R7: With mode 2'b11, both result words are zero and err_mode_o is 1.
- R8: For modes 00, 01 and 11, out_valid_o pulses high for one cycle, two clock edges after the edge that accepted the operation. A new operation of these modes can be accepted on every clock edge.
- R9: For mode 10, in_ready_o is low from the edge after acceptance until the result is delivered. out_valid_o then pulses 35 edges after the accepting edge.
- R10: While rst_ni is low, out_valid_o is 0, in_ready_o is 1, both result words are zero, and both flags are zero.
- R11: err_mode_o and div_zero_o describe the most recently delivered result. They are never both high, and each is low for any result that is not of its kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operation request |
| mode_i | input | 2 | Operation code: 00 add/sub, 01 multiply, 10 divide, 11 reserved |
| sub_i | input | 1 | Subtract select for mode 00 |
| a_int_i | input | 24 | Operand A integer field |
| a_frac_i | input | 8 | Operand A fraction field |
| b_int_i | input | 24 | Operand B integer field |
| b_frac_i | input | 8 | Operand B fraction field |
| in_ready_o | output | 1 | Unit can accept an operation this cycle |
| out_valid_o | output | 1 | One-cycle pulse marking a new result |
| res_lo_o | output | 32 | Sum/difference, product low word, or quotient |
| res_hi_o | output | 32 | Product high word or remainder; zero otherwise |
| err_mode_o | output | 1 | Result came from the reserved mode |
| div_zero_o | output | 1 | Result came from a divide by zero |

## Verification
The assertions assume that an operation is presented only with in_valid_i, and that it counts as issued only on an edge where in_ready_o is high. The two-cycle latency property relies on this, and so does the rule that no fixed-latency result can collide with a divide result. The stimulus complies by always waiting at a falling edge for in_ready_o before it raises in_valid_i, and by dropping in_valid_i one cycle later. Back-to-back issue is driven only with non-divide modes, because those are the only ones that keep in_ready_o high. The adder check assumes its operands settle once per cycle from registers, and that holds because the adder is fed only by the input stage.

// File: rtl/fx_arith_pkg.sv
package fx_arith_pkg;
  typedef enum logic [1:0] {
    MODE_ADDSUB = 2'b00,
    MODE_MUL    = 2'b01,
    MODE_DIV    = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;
endpackage

// File: rtl/fx_cla_adder.sv
module fx_cla_adder #(
  parameter int WIDTH = 32,
  parameter int GRP   = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o
);
  localparam int NGRP = WIDTH / GRP;

  logic [NGRP:0] c_grp;
  assign c_grp[0] = cin_i;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    logic [GRP-1:0] g, p, cb;
    logic           grp_g;
    assign g = a_i[gi*GRP +: GRP] & b_i[gi*GRP +: GRP];
    assign p = a_i[gi*GRP +: GRP] ^ b_i[gi*GRP +: GRP];

    // carry into each bit as a flat sum of products
    always_comb begin
      for (int b = 0; b < GRP; b++) begin
        logic prod;
        logic acc;
        prod = 1'b1;
        acc  = 1'b0;
        for (int j = GRP - 1; j >= 0; j--) begin
          if (j < b) begin
            acc  = acc | (g[j] & prod);
            prod = prod & p[j];
          end
        end
        cb[b] = acc | (prod & c_grp[gi]);
      end
    end

    always_comb begin
      logic prod;
      grp_g = 1'b0;
      prod  = 1'b1;
      for (int j = GRP - 1; j >= 0; j--) begin
        grp_g = grp_g | (g[j] & prod);
        prod  = prod & p[j];
      end
    end

    assign c_grp[gi+1]         = grp_g | ((&p) & c_grp[gi]);
    assign sum_o[gi*GRP +: GRP] = p ^ cb;
  end

  // R2 R3
  always_comb begin
    sum_ref_chk: assert (sum_o == WIDTH'(a_i + b_i + WIDTH'(cin_i)));
  end
endmodule

// File: rtl/fx_mul.sv
module fx_mul #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic [2*WIDTH-1:0] prod_o
);
  logic signed [2*WIDTH-1:0] ax, bx;
  assign ax     = {{WIDTH{a_i[WIDTH-1]}}, a_i};
  assign bx     = {{WIDTH{b_i[WIDTH-1]}}, b_i};
  assign prod_o = ax * bx;
endmodule

// File: rtl/fx_seq_div.sv
module fx_seq_div #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_o,
  output logic             dz_o
);
  localparam int CW = $clog2(WIDTH) + 1;

  logic [WIDTH-1:0] rem_q, quo_q, den_q, raw_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q, done_q, qneg_q, rneg_q, dz_q;
  logic [WIDTH:0]   shifted, diff;
  logic [WIDTH-1:0] rem_nxt, quo_nxt;

  function automatic logic [WIDTH-1:0] mag(input logic [WIDTH-1:0] x);
    return x[WIDTH-1] ? -x : x;
  endfunction

  assign shifted = {rem_q, quo_q[WIDTH-1]};
  assign diff    = shifted - {1'b0, den_q};
  assign rem_nxt = diff[WIDTH] ? shifted[WIDTH-1:0] : diff[WIDTH-1:0];
  assign quo_nxt = {quo_q[WIDTH-2:0], ~diff[WIDTH]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      raw_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      dz_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        rem_q  <= '0;
        quo_q  <= mag(dividend_i);
        den_q  <= mag(divisor_i);
        raw_q  <= dividend_i;
        qneg_q <= dividend_i[WIDTH-1] ^ divisor_i[WIDTH-1];
        rneg_q <= dividend_i[WIDTH-1];
        dz_q   <= (divisor_i == '0);
      end else if (busy_q) begin
        rem_q <= rem_nxt;
        quo_q <= quo_nxt;
        if (cnt_q == CW'(WIDTH - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign dz_o   = dz_q;
  assign quo_o  = dz_q ? '1    : (qneg_q ? -quo_q : quo_q);
  assign rem_o  = dz_q ? raw_q : (rneg_q ? -rem_q : rem_q);

  // R9
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q < CW'(WIDTH));
endmodule

// File: rtl/fx_arith_unit.sv
module fx_arith_unit
  import fx_arith_pkg::*;
#(
  parameter int INT_W  = 24,
  parameter int FRAC_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  input  logic [1:0]                mode_i,
  input  logic                      sub_i,
  input  logic [INT_W-1:0]          a_int_i,
  input  logic [FRAC_W-1:0]         a_frac_i,
  input  logic [INT_W-1:0]          b_int_i,
  input  logic [FRAC_W-1:0]         b_frac_i,
  output logic                      in_ready_o,
  output logic                      out_valid_o,
  output logic [INT_W+FRAC_W-1:0]   res_lo_o,
  output logic [INT_W+FRAC_W-1:0]   res_hi_o,
  output logic                      err_mode_o,
  output logic                      div_zero_o
);
  localparam int W = INT_W + FRAC_W;

  logic         s1_valid, s1_sub;
  mode_e        s1_mode;
  logic [W-1:0] s1_a, s1_b;
  logic         accept, div_start;

  logic [W-1:0]   add_b, add_sum;
  logic [2*W-1:0] prod;
  logic           div_busy, div_done, div_dz;
  logic [W-1:0]   div_quo, div_rem;

  logic         ov_q, err_q, dz_q;
  logic [W-1:0] lo_q, hi_q;

  assign div_start  = s1_valid && (s1_mode == MODE_DIV);
  assign in_ready_o = !div_start && !div_busy && !div_done;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_mode  <= MODE_ADDSUB;
      s1_sub   <= 1'b0;
      s1_a     <= '0;
      s1_b     <= '0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_mode <= mode_e'(mode_i);
        s1_sub  <= sub_i;
        s1_a    <= {a_int_i, a_frac_i};
        s1_b    <= {b_int_i, b_frac_i};
      end
    end
  end

  assign add_b = s1_sub ? ~s1_b : s1_b;

  fx_cla_adder #(.WIDTH(W), .GRP(4)) u_add (
    .a_i   (s1_a),
    .b_i   (add_b),
    .cin_i (s1_sub),
    .sum_o (add_sum)
  );

  fx_mul #(.WIDTH(W)) u_mul (
    .a_i    (s1_a),
    .b_i    (s1_b),
    .prod_o (prod)
  );

  fx_seq_div #(.WIDTH(W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (s1_a),
    .divisor_i  (s1_b),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quo_o      (div_quo),
    .rem_o      (div_rem),
    .dz_o       (div_dz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_q  <= 1'b0;
      err_q <= 1'b0;
      dz_q  <= 1'b0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (s1_valid && s1_mode != MODE_DIV) begin
      ov_q <= 1'b1;
      dz_q <= 1'b0;
      unique case (s1_mode)
        MODE_ADDSUB: begin lo_q <= add_sum;     hi_q <= '0;          err_q <= 1'b0; end
        MODE_MUL:    begin lo_q <= prod[W-1:0]; hi_q <= prod[2*W-1:W]; err_q <= 1'b0; end
        default:     begin lo_q <= '0;          hi_q <= '0;          err_q <= 1'b1; end
      endcase
    end else if (div_done) begin
      ov_q  <= 1'b1;
      lo_q  <= div_quo;
      hi_q  <= div_rem;
      err_q <= 1'b0;
      dz_q  <= div_dz;
    end else begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid_o = ov_q;
  assign res_lo_o    = lo_q;
  assign res_hi_o    = hi_q;
  assign err_mode_o  = err_q;
  assign div_zero_o  = dz_q;

  // R7
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && err_mode_o) |-> (res_lo_o == '0 && res_hi_o == '0));

  // R6
  dz_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && div_zero_o) |-> (res_lo_o == '1));

  // R11
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(err_mode_o && div_zero_o));

  // R8
  fixed_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && mode_i != 2'(MODE_DIV)) |=> ##1 out_valid_o);
endmodule

// File: tb/fx_arith_unit_tb.sv
`timescale 1ns/1ps
module fx_arith_unit_tb;
  typedef struct packed {
    logic [1:0]  mode;
    logic        sub;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] lo;
    logic [31:0] hi;
    logic        err;
    logic        dz;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 32'h00000F30, 32'h00000F30, 32'h00001E60, 32'h0, 1'b0, 1'b0},
    '{2'b00, 1'b1, 32'h00000F30, 32'h00001E60, 32'hFFFFF0D0, 32'h0, 1'b0, 1'b0},
    '{2'b00, 1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 32'h0, 1'b0, 1'b0},
    '{2'b00, 1'b1, 32'h00000000, 32'h80000000, 32'h80000000, 32'h0, 1'b0, 1'b0},
    '{2'b01, 1'b0, 32'h00001F03, 32'h0000070F, 32'h00DAE62D, 32'h0, 1'b0, 1'b0},
    '{2'b01, 1'b0, 32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFE, 32'hFFFFFFFF, 1'b0, 1'b0},
    '{2'b01, 1'b0, 32'h80000000, 32'h80000000, 32'h00000000, 32'h40000000, 1'b0, 1'b0},
    '{2'b10, 1'b0, 32'h0000000D, 32'h00000003, 32'h00000004, 32'h00000001, 1'b0, 1'b0},
    '{2'b10, 1'b0, 32'hFFFFFFF3, 32'h00000003, 32'hFFFFFFFC, 32'hFFFFFFFF, 1'b0, 1'b0},
    '{2'b10, 1'b0, 32'h0000000D, 32'hFFFFFFFD, 32'hFFFFFFFC, 32'h00000001, 1'b0, 1'b0},
    '{2'b10, 1'b0, 32'h80000000, 32'h00000001, 32'h80000000, 32'h00000000, 1'b0, 1'b0},
    '{2'b10, 1'b0, 32'h12345678, 32'h00000000, 32'hFFFFFFFF, 32'h12345678, 1'b0, 1'b1},
    '{2'b11, 1'b0, 32'h00000005, 32'h00000007, 32'h00000000, 32'h00000000, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        sub = 1'b0;
  logic [31:0] a_w = '0, b_w = '0;
  logic        in_ready, out_valid, err_mode, div_zero;
  logic [31:0] res_lo, res_hi;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  fx_arith_unit u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .mode_i      (mode),
    .sub_i       (sub),
    .a_int_i     (a_w[31:8]),
    .a_frac_i    (a_w[7:0]),
    .b_int_i     (b_w[31:8]),
    .b_frac_i    (b_w[7:0]),
    .in_ready_o  (in_ready),
    .out_valid_o (out_valid),
    .res_lo_o    (res_lo),
    .res_hi_o    (res_hi),
    .err_mode_o  (err_mode),
    .div_zero_o  (div_zero)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(vec_t v);
    if (v.mode == 2'b11) return "R7";
    if (v.mode == 2'b10) return (v.b == 0) ? "R6" : "R5";
    if (v.mode == 2'b01) return "R4";
    return v.sub ? "R3" : "R2";
  endfunction

  task automatic check_reset_state();
    chk("R10 out_valid", 64'(out_valid), 64'd0);
    chk("R10 in_ready",  64'(in_ready),  64'd1);
    chk("R10 results",   {res_hi, res_lo}, 64'd0);
    chk("R10 flags",     {62'd0, err_mode, div_zero}, 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;

    // table walk; operands split into 24.8 fields checks R1 joining
    for (int i = 0; i < NV; i++) begin
      int lat;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      mode = VECS[i].mode; sub = VECS[i].sub;
      a_w = VECS[i].a; b_w = VECS[i].b;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      if (VECS[i].mode == 2'b10) chk("R9 ready low", 64'(in_ready), 64'd0);
      lat = 1;
      while (!out_valid && lat < 60) begin
        @(negedge clk);
        lat++;
      end
      chk({tag_of(VECS[i]), " R1 lo"}, 64'(res_lo), 64'(VECS[i].lo));
      chk({tag_of(VECS[i]), " hi"},    64'(res_hi), 64'(VECS[i].hi));
      chk("R11 err flag",  64'(err_mode), 64'(VECS[i].err));
      chk("R11 dz flag",   64'(div_zero), 64'(VECS[i].dz));
      if (VECS[i].mode == 2'b10) chk("R9 latency", 64'(lat), 64'd35);
      else                       chk("R8 latency", 64'(lat), 64'd2);
      @(negedge clk);
      chk("R8 R9 single pulse", 64'(out_valid), 64'd0);
    end

    // R8 back-to-back issue
    @(negedge clk);
    mode = 2'b00; sub = 1'b0; a_w = 32'd1; b_w = 32'd2; in_valid = 1'b1;
    @(negedge clk);
    chk("R8 ready stays high", 64'(in_ready), 64'd1);
    mode = 2'b01; a_w = 32'd6; b_w = 32'd7;
    @(negedge clk);
    chk("R8 b2b first valid", 64'(out_valid), 64'd1);
    chk("R8 b2b first", 64'(res_lo), 64'd3);
    mode = 2'b00; sub = 1'b1; a_w = 32'd10; b_w = 32'd4;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 b2b second valid", 64'(out_valid), 64'd1);
    chk("R8 b2b second", {res_hi, res_lo}, 64'd42);
    @(negedge clk);
    chk("R8 b2b third valid", 64'(out_valid), 64'd1);
    chk("R8 b2b third", 64'(res_lo), 64'd6);
    @(negedge clk);
    chk("R8 b2b idle", 64'(out_valid), 64'd0);

    // R10 reset in the middle of a divide
    mode = 2'b10; sub = 1'b0; a_w = 32'd100; b_w = 32'd7; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R10 no stale result", 64'(out_valid), 64'd0);
    chk("R10 ready after reset", 64'(in_ready), 64'd1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule